// File: doc/BRIEF.md
# Two-Level Cache Message Queues with Class-Separated Drain Control

This block carries the traffic between a first-level and a second-level cache controller in a snooping hierarchy. Traffic is sorted into four classes, each held in its own FIFO. Towards the second level, the queues hold processor requests and intervention replies. Towards the first level, they hold intervention requests and processor replies. Keeping the classes apart removes any cycle from the graph of which queue waits on which. As a result, a full queue in one direction can never hold up a full queue in the other direction forever.

Each controller looks at the head of its inbound request queue and raises a take strobe. It also says whether that head message will produce a reply. The block then decides whether the head may be removed. A message that needs a reply is removed only in a cycle in which the queue for its reply has a free slot. The reply is written into that slot in the same cycle, so a removed message never has to be put back. Processor replies are always delivered to the first level, one per cycle. Intervention replies leave only in cycles in which the bus is granted. Cache lookup, bus arbitration and coherence state are outside the block: whether a reply is needed arrives as an input.

Top module: `l1l2_msg_queues`

## Requirements
- R1: After reset all four queues are empty: every head-valid output is 0 and both push-ready outputs are 1.
- R2: Each class queue keeps its messages in arrival order. A push-ready output is 0 while its queue holds its parameter depth of messages. A push made while the queue is full is dropped and never appears at the head.
- R3: A second-level take whose reply flag is 1 removes the processor-request head only when the processor-reply queue is not full. In that same cycle the reply data enters the processor-reply queue. `preq_pop` is 1 when the head is removed.
- R4: A take whose reply flag is 0 removes the head of its request queue whatever the fill level of the matching reply queue. This applies to the second-level controller and to the first-level controller alike.
- R5: A first-level take whose reply flag is 1 removes the intervention-request head only when the intervention-reply queue is not full. In that same cycle the reply data enters the intervention-reply queue. `ireq_pop` is 1 when the head is removed.
- R6: Whenever the processor-reply queue is non-empty, its head is presented on `prep_vld`/`prep_dat` and removed at the next clock edge, with no condition.
- R7: The intervention-reply head is presented on `irep_vld`/`irep_dat`. It is removed only at an edge where `bus_grant` is 1, and it stays unchanged otherwise.
- R8: The two drain decisions are independent. A second-level removal and a first-level removal, both needing replies, can happen in the same cycle.
- R9: A take made while its request queue is empty removes nothing and writes no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_req_push | input | 1 | First level writes a processor request |
| l1_req_dat | input | DATA_W | Processor request payload |
| l1_req_ready | output | 1 | Processor-request queue not full |
| l2_ir_push | input | 1 | Second level writes an intervention request |
| l2_ir_dat | input | DATA_W | Intervention request payload |
| l2_ir_ready | output | 1 | Intervention-request queue not full |
| preq_head_vld | output | 1 | Processor-request head present |
| preq_head_dat | output | DATA_W | Processor-request head payload |
| l2_take | input | 1 | Second level wants to consume the processor-request head |
| l2_reply_needed | input | 1 | That head will produce a processor reply |
| l2_reply_dat | input | DATA_W | Processor reply payload |
| preq_pop | output | 1 | Processor-request head removed this cycle |
| ireq_head_vld | output | 1 | Intervention-request head present |
| ireq_head_dat | output | DATA_W | Intervention-request head payload |
| l1_take | input | 1 | First level wants to consume the intervention-request head |
| l1_irep_needed | input | 1 | That head will produce an intervention reply |
| l1_irep_dat | input | DATA_W | Intervention reply payload |
| ireq_pop | output | 1 | Intervention-request head removed this cycle |
| prep_vld | output | 1 | Processor reply delivered to the first level this cycle |
| prep_dat | output | DATA_W | Processor reply payload |
| bus_grant | input | 1 | Bus granted for an intervention reply |
| irep_vld | output | 1 | Intervention-reply head present |
| irep_dat | output | DATA_W | Intervention-reply payload |

## Verification
The bench builds the block with DATA_W of 8, request-queue depths of 4 and reply-queue depths of 1. With single-slot reply queues, one reply is enough to fill a reply queue. That makes the blocked take, the removal of a no-reply message past a full reply queue, and the intervention reply held while there is no grant all reachable within a few cycles. The four-deep request queues are filled until ready drops and then pushed once more, which shows both the ordering and the dropped write. A scoreboard of expected replies is compared against both reply outputs.

// File: rtl/l1l2_mq_pkg.sv
package l1l2_mq_pkg;
    // Message class index; queues are instantiated per class
    typedef enum logic [1:0] {
        MC_PREQ = 2'd0,  // processor request, L1 -> L2
        MC_IREP = 2'd1,  // intervention reply, L1 -> L2
        MC_PREP = 2'd2,  // processor reply, L2 -> L1
        MC_IREQ = 2'd3   // intervention request, L2 -> L1
    } msg_class_e;

    localparam int unsigned NUM_CLASSES = 4;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 2,
    parameter int unsigned LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R9
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R2
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> level == $past(level) + LVL_W'(1));

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/mq_drain_gate.sv
module mq_drain_gate (
    input  logic take,
    input  logic head_vld,
    input  logic needs_reply,
    input  logic reply_full,
    output logic pop,
    output logic reply_push
);
    logic space_ok;

    // A reply-producing head leaves only together with its reserved slot
    always_comb begin
        space_ok   = !needs_reply || !reply_full;
        pop        = take && head_vld && space_ok;
        reply_push = pop && needs_reply;
    end
endmodule

// File: rtl/l1l2_msg_queues.sv
module l1l2_msg_queues
    import l1l2_mq_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned PREQ_DEPTH = 4,
    parameter int unsigned IREP_DEPTH = 2,
    parameter int unsigned PREP_DEPTH = 2,
    parameter int unsigned IREQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1_req_push,
    input  logic [DATA_W-1:0] l1_req_dat,
    output logic              l1_req_ready,
    input  logic              l2_ir_push,
    input  logic [DATA_W-1:0] l2_ir_dat,
    output logic              l2_ir_ready,
    output logic              preq_head_vld,
    output logic [DATA_W-1:0] preq_head_dat,
    input  logic              l2_take,
    input  logic              l2_reply_needed,
    input  logic [DATA_W-1:0] l2_reply_dat,
    output logic              preq_pop,
    output logic              ireq_head_vld,
    output logic [DATA_W-1:0] ireq_head_dat,
    input  logic              l1_take,
    input  logic              l1_irep_needed,
    input  logic [DATA_W-1:0] l1_irep_dat,
    output logic              ireq_pop,
    output logic              prep_vld,
    output logic [DATA_W-1:0] prep_dat,
    input  logic              bus_grant,
    output logic              irep_vld,
    output logic [DATA_W-1:0] irep_dat
);
    localparam int unsigned MAX_D = max4(PREQ_DEPTH, IREP_DEPTH, PREP_DEPTH, IREQ_DEPTH);
    localparam int unsigned LVL_W = $clog2(MAX_D + 1);

    logic              q_push  [NUM_CLASSES];
    logic [DATA_W-1:0] q_din   [NUM_CLASSES];
    logic              q_pop   [NUM_CLASSES];
    logic [DATA_W-1:0] q_dout  [NUM_CLASSES];
    logic              q_full  [NUM_CLASSES];
    logic              q_empty [NUM_CLASSES];
    logic [LVL_W-1:0]  q_lvl   [NUM_CLASSES];

    logic l2_pop, l2_rpush, l1_pop, l1_rpush;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        localparam int unsigned D =
            (c == int'(MC_PREQ)) ? PREQ_DEPTH :
            (c == int'(MC_IREP)) ? IREP_DEPTH :
            (c == int'(MC_PREP)) ? PREP_DEPTH : IREQ_DEPTH;
        mq_fifo #(.W(DATA_W), .DEPTH(D), .LVL_W(LVL_W)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[c]),
            .din   (q_din[c]),
            .pop   (q_pop[c]),
            .dout  (q_dout[c]),
            .full  (q_full[c]),
            .empty (q_empty[c]),
            .level (q_lvl[c])
        );
    end

    // Second-level controller draining processor requests
    mq_drain_gate u_l2_gate (
        .take        (l2_take),
        .head_vld    (!q_empty[MC_PREQ]),
        .needs_reply (l2_reply_needed),
        .reply_full  (q_full[MC_PREP]),
        .pop         (l2_pop),
        .reply_push  (l2_rpush)
    );

    // First-level controller draining intervention requests
    mq_drain_gate u_l1_gate (
        .take        (l1_take),
        .head_vld    (!q_empty[MC_IREQ]),
        .needs_reply (l1_irep_needed),
        .reply_full  (q_full[MC_IREP]),
        .pop         (l1_pop),
        .reply_push  (l1_rpush)
    );

    always_comb begin
        q_push[MC_PREQ] = l1_req_push;
        q_din [MC_PREQ] = l1_req_dat;
        q_pop [MC_PREQ] = l2_pop;

        q_push[MC_IREQ] = l2_ir_push;
        q_din [MC_IREQ] = l2_ir_dat;
        q_pop [MC_IREQ] = l1_pop;

        q_push[MC_PREP] = l2_rpush;
        q_din [MC_PREP] = l2_reply_dat;
        q_pop [MC_PREP] = !q_empty[MC_PREP];

        q_push[MC_IREP] = l1_rpush;
        q_din [MC_IREP] = l1_irep_dat;
        q_pop [MC_IREP] = bus_grant && !q_empty[MC_IREP];
    end

    always_comb begin
        l1_req_ready  = !q_full[MC_PREQ];
        l2_ir_ready   = !q_full[MC_IREQ];
        preq_head_vld = !q_empty[MC_PREQ];
        preq_head_dat = q_dout[MC_PREQ];
        preq_pop      = l2_pop;
        ireq_head_vld = !q_empty[MC_IREQ];
        ireq_head_dat = q_dout[MC_IREQ];
        ireq_pop      = l1_pop;
        prep_vld      = !q_empty[MC_PREP];
        prep_dat      = q_dout[MC_PREP];
        irep_vld      = !q_empty[MC_IREP];
        irep_dat      = q_dout[MC_IREP];
    end

    // R3
    prep_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preq_pop && l2_reply_needed) |-> q_lvl[MC_PREP] < LVL_W'(PREP_DEPTH));

    // R5
    irep_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ireq_pop && l1_irep_needed) |-> q_lvl[MC_IREP] < LVL_W'(IREP_DEPTH));

    // R6
    prep_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prep_vld && !q_push[MC_PREP]) |=> q_lvl[MC_PREP] == $past(q_lvl[MC_PREP]) - LVL_W'(1));

    // R7
    irep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_grant && !q_push[MC_IREP]) |=> $stable(q_lvl[MC_IREP]));
endmodule

// File: tb/l1l2_msg_queues_test.sv
module l1l2_msg_queues_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l1_req_push = 1'b0, l2_ir_push = 1'b0;
    logic [DW-1:0] l1_req_dat = '0, l2_ir_dat = '0;
    logic          l2_take = 1'b0, l2_reply_needed = 1'b0;
    logic [DW-1:0] l2_reply_dat = '0;
    logic          l1_take = 1'b0, l1_irep_needed = 1'b0;
    logic [DW-1:0] l1_irep_dat = '0;
    logic          bus_grant = 1'b0;
    logic          l1_req_ready, l2_ir_ready, preq_head_vld, ireq_head_vld;
    logic          preq_pop, ireq_pop, prep_vld, irep_vld;
    logic [DW-1:0] preq_head_dat, ireq_head_dat, prep_dat, irep_dat;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [DW-1:0] exp_prep [$];
    logic [DW-1:0] exp_irep [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    l1l2_msg_queues #(
        .DATA_W(DW), .PREQ_DEPTH(4), .IREP_DEPTH(1), .PREP_DEPTH(1), .IREQ_DEPTH(4)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .l1_req_push(l1_req_push), .l1_req_dat(l1_req_dat), .l1_req_ready(l1_req_ready),
        .l2_ir_push(l2_ir_push), .l2_ir_dat(l2_ir_dat), .l2_ir_ready(l2_ir_ready),
        .preq_head_vld(preq_head_vld), .preq_head_dat(preq_head_dat),
        .l2_take(l2_take), .l2_reply_needed(l2_reply_needed), .l2_reply_dat(l2_reply_dat),
        .preq_pop(preq_pop),
        .ireq_head_vld(ireq_head_vld), .ireq_head_dat(ireq_head_dat),
        .l1_take(l1_take), .l1_irep_needed(l1_irep_needed), .l1_irep_dat(l1_irep_dat),
        .ireq_pop(ireq_pop),
        .prep_vld(prep_vld), .prep_dat(prep_dat),
        .bus_grant(bus_grant), .irep_vld(irep_vld), .irep_dat(irep_dat)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // Monitor: reply outputs against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prep_vld) begin
                if (exp_prep.size() == 0) check("R6 unexpected processor reply", 32'(prep_dat), 32'hFFFF);
                else check("R6 processor reply", 32'(prep_dat), 32'(exp_prep.pop_front()));
            end
            if (irep_vld && bus_grant) begin
                if (exp_irep.size() == 0) check("R7 unexpected intervention reply", 32'(irep_dat), 32'hFFFF);
                else check("R7 intervention reply", 32'(irep_dat), 32'(exp_irep.pop_front()));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got 0x1 expected 0x0");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 preq_head_vld", 32'(preq_head_vld), 0);
        check("R1 ireq_head_vld", 32'(ireq_head_vld), 0);
        check("R1 prep_vld", 32'(prep_vld), 0);
        check("R1 irep_vld", 32'(irep_vld), 0);
        check("R1 ready", 32'({l1_req_ready, l2_ir_ready}), 32'h3);

        // R2: fill request queue, extra push dropped
        for (int i = 1; i <= 5; i++) begin
            cyc();
            l1_req_push = 1'b1;
            l1_req_dat  = DW'(i * 'h11);
        end
        @(negedge clk);
        check("R2 ready low when full", 32'(l1_req_ready), 0);
        check("R2 head order", 32'(preq_head_dat), 32'h11);
        cyc();
        l1_req_push = 1'b0;
        l2_ir_push = 1'b1; l2_ir_dat = 8'h81;
        cyc();
        l2_ir_dat = 8'h82;
        cyc();
        l2_ir_push = 1'b0;

        // R3: reply-needing take gated by processor-reply space
        l2_take = 1'b1; l2_reply_needed = 1'b1; l2_reply_dat = 8'hA1;
        @(negedge clk);
        check("R3 pop with space", 32'(preq_pop), 1);
        exp_prep.push_back(8'hA1);
        cyc();
        l2_reply_dat = 8'hA2;
        @(negedge clk);
        check("R3 pop blocked when reply queue full", 32'(preq_pop), 0);
        check("R3 head kept", 32'(preq_head_dat), 32'h22);
        cyc();
        @(negedge clk);
        check("R3 pop after reply drained", 32'(preq_pop), 1);
        exp_prep.push_back(8'hA2);
        cyc();
        l2_reply_needed = 1'b0;
        @(negedge clk);
        check("R4 no-reply pop past full reply queue", 32'(preq_pop), 1);
        check("R4 reply queue full meanwhile", 32'(prep_vld), 1);
        cyc();
        l2_take = 1'b0;

        // R5/R7: first-level side, no grant
        l1_take = 1'b1; l1_irep_needed = 1'b1; l1_irep_dat = 8'hC1;
        @(negedge clk);
        check("R5 pop with space", 32'(ireq_pop), 1);
        exp_irep.push_back(8'hC1);
        cyc();
        l1_irep_dat = 8'hC2;
        @(negedge clk);
        check("R5 pop blocked when reply queue full", 32'(ireq_pop), 0);
        check("R5 head kept", 32'(ireq_head_dat), 32'h82);
        check("R7 reply presented", 32'({irep_vld, irep_dat}), 32'h1C1);
        cyc();
        @(negedge clk);
        check("R7 reply held without grant", 32'({irep_vld, irep_dat}), 32'h1C1);
        cyc();
        l1_irep_needed = 1'b0;
        @(negedge clk);
        check("R4 first-level no-reply pop", 32'(ireq_pop), 1);
        cyc();
        l1_take = 1'b0;
        bus_grant = 1'b1;
        cyc();
        bus_grant = 1'b0;
        @(negedge clk);
        check("R7 reply removed on grant", 32'(irep_vld), 0);

        // R8: both directions drain in the same cycle
        cyc();
        l2_ir_push = 1'b1; l2_ir_dat = 8'h83;
        cyc();
        l2_ir_push = 1'b0;
        l2_take = 1'b1; l2_reply_needed = 1'b1; l2_reply_dat = 8'hA3;
        l1_take = 1'b1; l1_irep_needed = 1'b1; l1_irep_dat = 8'hC3;
        @(negedge clk);
        check("R8 both pops same cycle", 32'({preq_pop, ireq_pop}), 32'h3);
        check("R8 processor-request head", 32'(preq_head_dat), 32'h44);
        exp_prep.push_back(8'hA3);
        exp_irep.push_back(8'hC3);
        cyc();
        l2_take = 1'b0; l1_take = 1'b0;
        @(negedge clk);
        check("R2 dropped push never appears", 32'(preq_head_vld), 0);
        check("R2 intervention queue empty", 32'(ireq_head_vld), 0);

        // R9: take on empty queue
        cyc();
        l2_take = 1'b1; l2_reply_needed = 1'b1; l2_reply_dat = 8'hEE;
        l1_take = 1'b1; l1_irep_needed = 1'b1; l1_irep_dat = 8'hEF;
        @(negedge clk);
        check("R9 no pop on empty", 32'({preq_pop, ireq_pop}), 0);
        cyc();
        l2_take = 1'b0; l1_take = 1'b0;
        @(negedge clk);
        check("R9 no reply written", 32'(prep_vld), 0);
        check("R9 only earlier intervention reply", 32'({irep_vld, irep_dat}), 32'h1C3);
        bus_grant = 1'b1;
        cyc();
        bus_grant = 1'b0;
        repeat (3) cyc();
        @(negedge clk);
        check("R6 scoreboard drained", 32'(exp_prep.size()), 0);
        check("R7 scoreboard drained", 32'(exp_irep.size()), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule